// File: doc/BRIEF.md
# SPI Word Buffer Pair

This block sits between a processor register port and a serial shift engine. It holds two queues of 32-bit words. The transmit queue is filled by the processor and drained by the engine. The receive queue is filled by the engine and drained by the processor. Both queues report occupancy, empty, full and a threshold flag. The two threshold flags use opposite tests. The transmit flag asks for more data while the queue is nearly drained. The receive flag reports that the queue has filled past a set level.

The receive side also has two error indications. A sticky overrun flag records a word that arrived while the receive queue was full. An inactivity flag is raised when received data has waited unread for a fixed number of serial clock periods.

Software may request that either queue be emptied. The request is carried out by a multi-step sequence that waits a fixed number of system cycles and then a fixed number of engine clock pulses before it wipes the queue. A busy output stays high for the whole sequence. Everything runs on one clock. The serial clock and the engine clock are given as single-cycle enable pulses.

Top module: `spi_word_buffers`

## Requirements
- R1: After reset both queues are empty with a count of 0, the transmit threshold flag is 1, and the receive threshold flag, overrun, time-out, busy and both pending bits are 0.
- R2: Each queue holds up to 8 words (DEPTH). Words leave in the order they were accepted. The 4-bit count equals accepted writes minus accepted reads, and full is 1 exactly when the count is 8.
- R3: A write to the full transmit queue is dropped and the contents do not change. A read of the empty receive queue returns 0 and leaves the count at 0.
- R4: `rx_high` is 1 exactly when `rx_count` is greater than the 2-bit `rx_thresh`.
- R5: `tx_low` is 1 exactly when `tx_count` is less than or equal to the 2-bit `tx_thresh`.
- R6: An engine push while the receive queue is full is discarded and sets `rx_overrun` at the next edge. The flag stays set until a cycle with `ovr_clr` high and no new drop. When a drop and `ovr_clr` arrive together, the flag stays set.
- R7: `rx_timeout` sets on the 64th `sclk_tick` pulse counted while the receive queue is non-empty and there has been no read and no push. It is never 1 while the queue is empty.
- R8: Any `cpu_rx_rd` strobe clears `rx_timeout` at the next edge. The tick count restarts from 0 on every read strobe and every push strobe.
- R9: A clear request sets its pending bit and `clr_busy` at the next edge. The sequence first waits 3 clock cycles and then counts 3 `eng_tick` pulses. On the edge of the third pulse the queue is emptied (full 0, empty 1) and the pending bit and busy drop.
- R10: A clear request wipes only the queue it names. The other queue keeps its words and count.
- R11: `cpu_rx_rdata` and `eng_tx_data` show the head word of their queue in the same cycle, and 0 while that queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_tx_wr | input | 1 | Processor write strobe into the transmit queue |
| cpu_tx_wdata | input | 32 | Word to write |
| cpu_rx_rd | input | 1 | Processor read strobe from the receive queue |
| cpu_rx_rdata | output | 32 | Head of the receive queue, 0 when empty |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 32 | Head of the transmit queue, 0 when empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| sclk_tick | input | 1 | One pulse per serial clock period |
| eng_tick | input | 1 | One pulse per engine clock |
| rx_thresh | input | 2 | Receive threshold level |
| tx_thresh | input | 2 | Transmit threshold level |
| clr_tx_req | input | 1 | Request to empty the transmit queue |
| clr_rx_req | input | 1 | Request to empty the receive queue |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| clr_tx_pend | output | 1 | Transmit clear still in progress |
| clr_rx_pend | output | 1 | Receive clear still in progress |
| clr_busy | output | 1 | Clear sequence active |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_count | output | 4 | Transmit occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_count | output | 4 | Receive occupancy |
| tx_low | output | 1 | Transmit count at or below threshold |
| rx_high | output | 1 | Receive count above threshold |
| rx_overrun | output | 1 | Sticky receive overrun |
| rx_timeout | output | 1 | Receive inactivity flag |

## Verification
The head data and both threshold flags are combinational, so the bench reads them in the same cycle as the state they come from. Counts, empty, full, overrun and time-out change on the edge that samples the strobe, and the bench reads them just after that edge. The time-out bench counts `sclk_tick` pulses itself and checks both sides of the 64th pulse. A clear is due six edges after its request edge when `eng_tick` is held high. When the engine pulses are held back, the clear is due on the third pulse given after the system wait has ended. The bench checks busy one edge before the due edge and again on it.

// File: rtl/spi_wb_pkg.sv
package spi_wb_pkg;
    typedef enum logic [1:0] {
        CLR_IDLE = 2'd0,
        CLR_SYS  = 2'd1,
        CLR_ENG  = 2'd2
    } clr_phase_e;
endpackage

// File: rtl/swb_fifo.sv
module swb_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           wr_en,
    input  logic [WIDTH-1:0]               wr_data,
    input  logic                           rd_en,
    output logic [WIDTH-1:0]               rd_data,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_wr, do_rd;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;
    assign rd_data = empty ? '0 : mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_wr) st_d.wp = ptr_next(st_q.wp);
            if (do_rd) st_d.rp = ptr_next(st_q.rp);
            st_d.cnt = st_q.cnt + CW'(do_wr) - CW'(do_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr && !flush) mem_q[st_q.wp] <= wr_data;
    end
endmodule

// File: rtl/swb_clear_seq.sv
module swb_clear_seq
    import spi_wb_pkg::*;
#(
    parameter int SYS_WAIT = 3,
    parameter int ENG_WAIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_tx,
    input  logic req_rx,
    input  logic eng_tick,
    output logic pend_tx,
    output logic pend_rx,
    output logic busy,
    output logic flush_tx,
    output logic flush_rx
);
    localparam int MAXW = (SYS_WAIT > ENG_WAIT) ? SYS_WAIT : ENG_WAIT;
    localparam int CW   = $clog2(MAXW + 1);

    typedef struct packed {
        clr_phase_e    ph;
        logic [CW-1:0] cnt;
        logic          ptx;
        logic          prx;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        flush_tx = 1'b0;
        flush_rx = 1'b0;
        case (st_q.ph)
            CLR_IDLE: begin
                if (req_tx || req_rx) begin
                    st_d.ph  = CLR_SYS;
                    st_d.cnt = '0;
                    st_d.ptx = req_tx;
                    st_d.prx = req_rx;
                end
            end
            CLR_SYS: begin
                st_d.ptx = st_q.ptx | req_tx;
                st_d.prx = st_q.prx | req_rx;
                if (st_q.cnt == CW'(SYS_WAIT - 1)) begin
                    st_d.ph  = CLR_ENG;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            CLR_ENG: begin
                st_d.ptx = st_q.ptx | req_tx;
                st_d.prx = st_q.prx | req_rx;
                if (eng_tick) begin
                    if (st_q.cnt == CW'(ENG_WAIT - 1)) begin
                        flush_tx = st_q.ptx;
                        flush_rx = st_q.prx;
                        st_d.ptx = req_tx;
                        st_d.prx = req_rx;
                        st_d.cnt = '0;
                        st_d.ph  = (req_tx || req_rx) ? CLR_SYS : CLR_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_tx = st_q.ptx;
    assign pend_rx = st_q.prx;
    assign busy    = (st_q.ph != CLR_IDLE);
endmodule

// File: rtl/swb_rx_idle.sv
module swb_rx_idle #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic read_evt,
    input  logic push_evt,
    input  logic flush,
    input  logic fifo_empty,
    input  logic tick,
    output logic timeout
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (read_evt || flush) st_d.flag = 1'b0;
        if (read_evt || push_evt || flush) begin
            st_d.cnt = '0;
        end else if (!fifo_empty && tick && st_q.cnt != CW'(LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(LIMIT - 1)) st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign timeout = st_q.flag;
endmodule

// File: rtl/spi_word_buffers.sv
module spi_word_buffers #(
    parameter int DEPTH         = 8,
    parameter int WIDTH         = 32,
    parameter int TH_W          = 2,
    parameter int TIMEOUT_TICKS = 64,
    parameter int SYS_WAIT      = 3,
    parameter int ENG_WAIT      = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_tx_wr,
    input  logic [WIDTH-1:0]           cpu_tx_wdata,
    input  logic                       cpu_rx_rd,
    output logic [WIDTH-1:0]           cpu_rx_rdata,
    input  logic                       eng_tx_pop,
    output logic [WIDTH-1:0]           eng_tx_data,
    input  logic                       eng_rx_push,
    input  logic [WIDTH-1:0]           eng_rx_data,
    input  logic                       sclk_tick,
    input  logic                       eng_tick,
    input  logic [TH_W-1:0]            rx_thresh,
    input  logic [TH_W-1:0]            tx_thresh,
    input  logic                       clr_tx_req,
    input  logic                       clr_rx_req,
    input  logic                       ovr_clr,
    output logic                       clr_tx_pend,
    output logic                       clr_rx_pend,
    output logic                       clr_busy,
    output logic                       tx_empty,
    output logic                       tx_full,
    output logic [$clog2(DEPTH+1)-1:0] tx_count,
    output logic                       rx_empty,
    output logic                       rx_full,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       tx_low,
    output logic                       rx_high,
    output logic                       rx_overrun,
    output logic                       rx_timeout
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic ovr;
    } top_st_t;

    top_st_t st_d, st_q;
    logic flush_tx, flush_rx;
    logic rx_drop;

    swb_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_tx),
        .wr_en   (cpu_tx_wr),
        .wr_data (cpu_tx_wdata),
        .rd_en   (eng_tx_pop),
        .rd_data (eng_tx_data),
        .count   (tx_count),
        .empty   (tx_empty),
        .full    (tx_full)
    );

    swb_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_rx),
        .wr_en   (eng_rx_push),
        .wr_data (eng_rx_data),
        .rd_en   (cpu_rx_rd),
        .rd_data (cpu_rx_rdata),
        .count   (rx_count),
        .empty   (rx_empty),
        .full    (rx_full)
    );

    swb_clear_seq #(.SYS_WAIT(SYS_WAIT), .ENG_WAIT(ENG_WAIT)) u_clear (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_tx   (clr_tx_req),
        .req_rx   (clr_rx_req),
        .eng_tick (eng_tick),
        .pend_tx  (clr_tx_pend),
        .pend_rx  (clr_rx_pend),
        .busy     (clr_busy),
        .flush_tx (flush_tx),
        .flush_rx (flush_rx)
    );

    swb_rx_idle #(.LIMIT(TIMEOUT_TICKS)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .read_evt   (cpu_rx_rd),
        .push_evt   (eng_rx_push),
        .flush      (flush_rx),
        .fifo_empty (rx_empty),
        .tick       (sclk_tick),
        .timeout    (rx_timeout)
    );

    assign rx_drop = eng_rx_push && rx_full && !flush_rx;

    always_comb begin
        st_d = st_q;
        if (rx_drop)      st_d.ovr = 1'b1;
        else if (ovr_clr) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_overrun = st_q.ovr;
    assign rx_high    = (rx_count > CW'(rx_thresh));
    assign tx_low     = (tx_count <= CW'(tx_thresh));
endmodule

// File: rtl/swb_checker.sv
module swb_checker #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cpu_tx_wr,
    input logic                       eng_tx_pop,
    input logic                       eng_rx_push,
    input logic                       cpu_rx_rd,
    input logic                       ovr_clr,
    input logic                       clr_tx_req,
    input logic                       clr_rx_req,
    input logic                       clr_tx_pend,
    input logic                       clr_rx_pend,
    input logic                       clr_busy,
    input logic                       tx_full,
    input logic                       tx_empty,
    input logic                       rx_full,
    input logic                       rx_empty,
    input logic [$clog2(DEPTH+1)-1:0] tx_count,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic                       rx_overrun,
    input logic                       rx_timeout
);
    localparam int CW = $clog2(DEPTH + 1);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    a_r3_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && cpu_tx_wr && !eng_tx_pop && !clr_tx_pend |=> tx_full);

    a_r6_overrun_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && eng_rx_push && !clr_rx_pend |=> rx_overrun);

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun && !ovr_clr |=> rx_overrun);

    a_r7_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> !rx_empty);

    a_r8_read_clears_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rx_rd |=> !rx_timeout);

    a_r9_req_makes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tx_req || clr_rx_req) |=> clr_busy);

    a_r9_tx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_tx_pend) |-> tx_empty);

    a_r9_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_rx_pend) |-> rx_empty);
endmodule

bind spi_word_buffers swb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_tx_wr   (cpu_tx_wr),
    .eng_tx_pop  (eng_tx_pop),
    .eng_rx_push (eng_rx_push),
    .cpu_rx_rd   (cpu_rx_rd),
    .ovr_clr     (ovr_clr),
    .clr_tx_req  (clr_tx_req),
    .clr_rx_req  (clr_rx_req),
    .clr_tx_pend (clr_tx_pend),
    .clr_rx_pend (clr_rx_pend),
    .clr_busy    (clr_busy),
    .tx_full     (tx_full),
    .tx_empty    (tx_empty),
    .rx_full     (rx_full),
    .rx_empty    (rx_empty),
    .tx_count    (tx_count),
    .rx_count    (rx_count),
    .rx_overrun  (rx_overrun),
    .rx_timeout  (rx_timeout)
);

// File: tb/spi_word_buffers_tb.sv
`timescale 1ns/1ps
module spi_word_buffers_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_tx_wr = 1'b0;
    logic [31:0] cpu_tx_wdata = '0;
    logic        cpu_rx_rd = 1'b0;
    logic [31:0] cpu_rx_rdata;
    logic        eng_tx_pop = 1'b0;
    logic [31:0] eng_tx_data;
    logic        eng_rx_push = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic        sclk_tick = 1'b0;
    logic        eng_tick = 1'b0;
    logic [1:0]  rx_thresh = '0;
    logic [1:0]  tx_thresh = '0;
    logic        clr_tx_req = 1'b0;
    logic        clr_rx_req = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        clr_tx_pend, clr_rx_pend, clr_busy;
    logic        tx_empty, tx_full, rx_empty, rx_full;
    logic [3:0]  tx_count, rx_count;
    logic        tx_low, rx_high, rx_overrun, rx_timeout;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    spi_word_buffers u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_tx_wr(cpu_tx_wr), .cpu_tx_wdata(cpu_tx_wdata),
        .cpu_rx_rd(cpu_rx_rd), .cpu_rx_rdata(cpu_rx_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .sclk_tick(sclk_tick), .eng_tick(eng_tick),
        .rx_thresh(rx_thresh), .tx_thresh(tx_thresh),
        .clr_tx_req(clr_tx_req), .clr_rx_req(clr_rx_req), .ovr_clr(ovr_clr),
        .clr_tx_pend(clr_tx_pend), .clr_rx_pend(clr_rx_pend), .clr_busy(clr_busy),
        .tx_empty(tx_empty), .tx_full(tx_full), .tx_count(tx_count),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_count(rx_count),
        .tx_low(tx_low), .rx_high(rx_high),
        .rx_overrun(rx_overrun), .rx_timeout(rx_timeout)
    );

    // {fill count[3:0], threshold[1:0], expected rx_high, expected tx_low}
    localparam logic [7:0] VEC [8] = '{
        8'b0000_00_0_1, 8'b0001_00_1_0, 8'b0001_01_0_1, 8'b0010_01_1_0,
        8'b0011_11_0_1, 8'b0100_11_1_0, 8'b1000_11_1_0, 8'b0010_10_0_1
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tx_write(input logic [31:0] d);
        cpu_tx_wr = 1'b1; cpu_tx_wdata = d; step(); cpu_tx_wr = 1'b0;
    endtask

    task automatic eng_push(input logic [31:0] d);
        eng_rx_push = 1'b1; eng_rx_data = d; step(); eng_rx_push = 1'b0;
    endtask

    task automatic rx_read(output logic [31:0] d);
        d = cpu_rx_rdata; cpu_rx_rd = 1'b1; step(); cpu_rx_rd = 1'b0;
    endtask

    task automatic eng_pop(output logic [31:0] d);
        d = eng_tx_data; eng_tx_pop = 1'b1; step(); eng_tx_pop = 1'b0;
    endtask

    task automatic ticks(input int n);
        sclk_tick = 1'b1; repeat (n) step(); sclk_tick = 1'b0;
    endtask

    task automatic drain();
        logic [31:0] d;
        while (!tx_empty) eng_pop(d);
        while (!rx_empty) rx_read(d);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_empty", rx_empty, 1);
        check("R1 tx_count", tx_count, 0);
        check("R1 rx_count", rx_count, 0);
        check("R1 tx_low", tx_low, 1);
        check("R1 rx_high", rx_high, 0);
        check("R1 overrun/timeout/busy", {rx_overrun, rx_timeout, clr_busy, clr_tx_pend, clr_rx_pend}, 0);

        // R4 R5 threshold table
        for (int i = 0; i < 8; i++) begin
            drain();
            for (int k = 0; k < int'(VEC[i][7:4]); k++) begin
                tx_write(32'h10 + k);
                eng_push(32'h20 + k);
            end
            rx_thresh = VEC[i][3:2];
            tx_thresh = VEC[i][3:2];
            #1;
            check("R4 rx_high table", rx_high, VEC[i][1]);
            check("R5 tx_low table", tx_low, VEC[i][0]);
        end
        drain();

        // R2 order and count, R11 head data
        tx_write(32'hA1); tx_write(32'hB2); tx_write(32'hC3);
        check("R2 tx_count 3", tx_count, 3);
        check("R11 tx head", eng_tx_data, 32'hA1);
        eng_pop(d); check("R2 order 1", d, 32'hA1);
        eng_pop(d); check("R2 order 2", d, 32'hB2);
        eng_pop(d); check("R2 order 3", d, 32'hC3);
        check("R11 tx data zero when empty", eng_tx_data, 0);

        // R2 full, R3 write to full dropped
        for (int k = 0; k < 8; k++) tx_write(32'h100 + k);
        check("R2 tx_full", tx_full, 1);
        check("R2 tx_count 8", tx_count, 8);
        tx_write(32'hDEAD);
        check("R3 count after full write", tx_count, 8);
        for (int k = 0; k < 8; k++) begin
            eng_pop(d);
            check("R3 contents unchanged", d, 32'h100 + k);
        end
        check("R3 no extra word", tx_empty, 1);

        // R3 read of empty rx
        rx_read(d);
        check("R3 empty read data", d, 0);
        check("R3 empty read count", rx_count, 0);

        // R6 overrun
        for (int k = 0; k < 8; k++) eng_push(32'h200 + k);
        check("R6 no overrun before drop", rx_overrun, 0);
        eng_push(32'h999);
        check("R6 overrun set", rx_overrun, 1);
        check("R6 count stays 8", rx_count, 8);
        eng_rx_push = 1'b1; eng_rx_data = 32'h998; ovr_clr = 1'b1; step();
        eng_rx_push = 1'b0; ovr_clr = 1'b0;
        check("R6 set wins over clear", rx_overrun, 1);
        ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
        check("R6 cleared", rx_overrun, 0);
        for (int k = 0; k < 8; k++) begin
            rx_read(d);
            check("R6 dropped words absent", d, 32'h200 + k);
        end
        check("R6 rx empty", rx_empty, 1);

        // R7 timeout edge
        eng_push(32'h55);
        ticks(63);
        check("R7 not set at 63", rx_timeout, 0);
        ticks(1);
        check("R7 set at 64", rx_timeout, 1);
        rx_read(d);
        check("R8 read clears timeout", rx_timeout, 0);
        check("R11 rx head data", d, 32'h55);
        ticks(70);
        check("R7 empty queue no timeout", rx_timeout, 0);

        // R8 restart on push
        eng_push(32'h1);
        ticks(40);
        eng_push(32'h2);
        ticks(40);
        check("R8 restart on push", rx_timeout, 0);
        ticks(23);
        check("R8 63 after push", rx_timeout, 0);
        ticks(1);
        check("R8 64 after push", rx_timeout, 1);
        drain();

        // R9 R10 tx clear with held-back engine pulses
        tx_write(32'h31); tx_write(32'h32);
        eng_push(32'h41); eng_push(32'h42);
        clr_tx_req = 1'b1; step(); clr_tx_req = 1'b0;
        check("R9 pending set", clr_tx_pend, 1);
        check("R9 busy set", clr_busy, 1);
        repeat (10) step();
        check("R9 waits for engine pulses", tx_count, 2);
        eng_tick = 1'b1; step(); eng_tick = 1'b0;
        eng_tick = 1'b1; step(); eng_tick = 1'b0;
        check("R9 busy after two pulses", clr_busy, 1);
        eng_tick = 1'b1; step(); eng_tick = 1'b0;
        check("R9 busy drops", clr_busy, 0);
        check("R9 pending drops", clr_tx_pend, 0);
        check("R9 tx emptied", tx_empty, 1);
        check("R10 rx untouched", rx_count, 2);

        // R9 rx clear with engine pulses every cycle
        for (int k = 0; k < 6; k++) eng_push(32'h50 + k);
        check("R9 rx_full before clear", rx_full, 1);
        eng_tick = 1'b1;
        clr_rx_req = 1'b1; step(); clr_rx_req = 1'b0;
        repeat (5) step();
        check("R9 busy one edge early", clr_busy, 1);
        check("R9 rx count kept until done", rx_count, 8);
        step();
        eng_tick = 1'b0;
        check("R9 rx busy drops", clr_busy, 0);
        check("R9 rx emptied", rx_empty, 1);
        check("R9 rx full drops", rx_full, 0);
        check("R10 tx untouched by rx clear", tx_count, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule